// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the serial-port pins and a serial command engine and provides the pause function of an active-low hold input. The pins arrive already synchronised to the system clock. The block turns the sampled serial clock into one-cycle rising-edge and falling-edge enables for the engine. While a pause is in force, it suppresses those enables so that the engine's bit counters, byte counters and shift registers stay frozen. It also forces the serial data output to high impedance. When the pause ends, the engine picks up at the bit after the last edge it was given.

A pause can begin or end only while the serial clock is low. If the hold input moves while the clock is high, the change waits until the clock is next seen low. Raising chip select during a pause does not resume the command. It raises a one-cycle abort pulse so the engine can discard its partial command, and the block returns to idle. Protocol decoding and memory access are not part of this block.

The controller has three states: IDLE (chip select high), RUN (command active) and HOLD (paused). It makes these transitions:
- START: IDLE to RUN on chip select low.
- END: RUN to IDLE on chip select high.
- PAUSE: RUN to HOLD on hold low with the clock low.
- RESUME: HOLD to RUN on hold high with the clock low.
- ABORT: HOLD to IDLE on chip select high.

Top module: `spi_hold_pause`

## Requirements
- R1: During reset and in the first cycle after it, both edge enables, `so_oe`, `so_data`, `hold_active` and `cmd_abort` are 0. The sampled previous serial clock resets to 0.
- R2: While `cs_n` is 1, the block produces no edge enable and no output enable, and any activity on `hold_n` leaves `hold_active` at 0.
- R3: In RUN with `cs_n` low, `sck_rise_en` is 1 for exactly the cycle in which `sck` is 1 and its previous sample was 0. `sck_fall_en` is 1 for the opposite change. Each clock edge gives exactly one pulse.
- R4: In RUN, if `hold_n` is 0 and `sck` is 0 in the same cycle, the block enters HOLD and `hold_active` becomes 1 in the next cycle.
- R5: If `hold_n` goes 0 while `sck` is 1, `hold_active` stays 0. It becomes 1 in the cycle after `sck` is first seen at 0 with `hold_n` still 0.
- R6: While `hold_active` is 1, toggling `sck` produces no edge enable, and `so_oe` and `so_data` are 0 whatever the engine drives.
- R7: In HOLD, if `hold_n` is 1 and `sck` is 0, `hold_active` drops in the next cycle. Edge enables then resume, and the count of rising enables in a command equals the rising clock edges made outside the pause.
- R8: Raising `hold_n` while `sck` is 1 keeps the block in HOLD until `sck` is seen at 0.
- R9: `cs_n` going 1 during HOLD gives `cmd_abort` = 1 in that same cycle, then IDLE with `hold_active` 0. `cs_n` going 1 during RUN gives no abort pulse.
- R10: In RUN with `cs_n` low, `so_oe` equals `eng_so_en`, and `so_data` equals `eng_so` when enabled and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock level |
| hold_n | input | 1 | Synchronised pause request, active low |
| eng_so | input | SO_W | Engine serial output data |
| eng_so_en | input | 1 | Engine serial output enable |
| sck_rise_en | output | 1 | One-cycle enable for a rising serial clock edge |
| sck_fall_en | output | 1 | One-cycle enable for a falling serial clock edge |
| so_data | output | SO_W | Gated serial output data |
| so_oe | output | 1 | Gated serial output enable (0 = high impedance) |
| hold_active | output | 1 | 1 while in the HOLD state |
| cmd_abort | output | 1 | One-cycle pulse when chip select rises during a pause |

## Verification
The main function is exercised with clock bursts that contain no pause, and with pauses entered and left while the clock is low. This separates correct edge counting from lost or extra edges. Pause requests and releases made while the clock is high show whether the transition is properly deferred rather than taken at once. Clock toggles and engine output activity during a pause show that the gating is complete. Raising chip select inside and outside a pause separates the abort path from a normal command end.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } hold_state_e;
endpackage

// File: rtl/hold_sck_edge.sv
// Detects level changes of the synchronised serial clock.
module hold_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    always_comb begin
        rise = sck & ~sck_q;
        fall = ~sck & sck_q;
    end
endmodule

// File: rtl/hold_fsm.sv
// Pause state machine: IDLE / RUN / HOLD.
module hold_fsm
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic hold_n,
    input  logic sck,
    output logic running,
    output logic held,
    output logic abort
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_n) state_d = ST_RUN;                  // START
            ST_RUN: begin
                if (cs_n)                 state_d = ST_IDLE;       // END
                else if (!hold_n && !sck) state_d = ST_HOLD;       // PAUSE
            end
            ST_HOLD: begin
                if (cs_n)                 state_d = ST_IDLE;       // ABORT
                else if (hold_n && !sck)  state_d = ST_RUN;        // RESUME
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running = 1'b0;
        held    = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  running = !cs_n;
            ST_HOLD: begin
                held  = 1'b1;
                abort = cs_n;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hold_so_gate.sv
// Forces the serial output to an idle, disabled value unless passing.
module hold_so_gate #(
    parameter int SO_W = 1
) (
    input  logic            pass_en,
    input  logic [SO_W-1:0] eng_so,
    input  logic            eng_so_en,
    output logic [SO_W-1:0] so_data,
    output logic            so_oe
);
    assign so_oe = pass_en & eng_so_en;

    for (genvar g = 0; g < SO_W; g++) begin : g_lane
        assign so_data[g] = so_oe & eng_so[g];
    end
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause #(
    parameter int SO_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            hold_n,
    input  logic [SO_W-1:0] eng_so,
    input  logic            eng_so_en,
    output logic            sck_rise_en,
    output logic            sck_fall_en,
    output logic [SO_W-1:0] so_data,
    output logic            so_oe,
    output logic            hold_active,
    output logic            cmd_abort
);
    logic rise, fall, running;

    hold_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (rise),
        .fall  (fall)
    );

    hold_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .hold_n  (hold_n),
        .sck     (sck),
        .running (running),
        .held    (hold_active),
        .abort   (cmd_abort)
    );

    hold_so_gate #(.SO_W(SO_W)) u_gate (
        .pass_en   (running),
        .eng_so    (eng_so),
        .eng_so_en (eng_so_en),
        .so_data   (so_data),
        .so_oe     (so_oe)
    );

    assign sck_rise_en = running & rise;
    assign sck_fall_en = running & fall;
endmodule

// File: rtl/spi_hold_pause_chk.sv
module spi_hold_pause_chk #(
    parameter int SO_W = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            sck,
    input logic            hold_n,
    input logic            sck_rise_en,
    input logic            sck_fall_en,
    input logic [SO_W-1:0] so_data,
    input logic            so_oe,
    input logic            hold_active,
    input logic            cmd_abort
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!hold_active && !sck_rise_en && !sck_fall_en && !so_oe && !cmd_abort));

    p_no_edge_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck_rise_en && !sck_fall_en && !so_oe));

    p_pause_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> $past(!hold_n && !sck && !cs_n));

    p_held_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!sck_rise_en && !sck_fall_en && !so_oe));

    p_pause_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_active) |-> $past(cs_n || (hold_n && !sck)));

    p_stay_held_sck_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !cs_n && sck) |=> hold_active);

    p_abort_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> (hold_active && cs_n));

    p_abort_leaves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> !hold_active);

    p_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> (so_data == '0));
endmodule

bind spi_hold_pause spi_hold_pause_chk #(.SO_W(SO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sck         (sck),
    .hold_n      (hold_n),
    .sck_rise_en (sck_rise_en),
    .sck_fall_en (sck_fall_en),
    .so_data     (so_data),
    .so_oe       (so_oe),
    .hold_active (hold_active),
    .cmd_abort   (cmd_abort)
);

// File: tb/spi_hold_pause_bench.sv
`timescale 1ns/1ps
module spi_hold_pause_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic hold_n = 1'b1;
    logic [0:0] eng_so = 1'b0;
    logic eng_so_en = 1'b0;
    logic sck_rise_en, sck_fall_en, so_oe, hold_active, cmd_abort;
    logic [0:0] so_data;

    int compared = 0;
    int mismatched = 0;
    int rise_cnt = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 active, 2 paused
    int m_st = 0;
    logic m_prev_sck = 1'b0;

    always #10 clk = ~clk;

    spi_hold_pause u_spi_hold_pause (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .eng_so(eng_so), .eng_so_en(eng_so_en),
        .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
        .so_data(so_data), .so_oe(so_oe),
        .hold_active(hold_active), .cmd_abort(cmd_abort)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the behavioural model, away from the edge
    always @(negedge clk) begin
        logic active;
        logic [5:0] exp_v, act_v;
        cycles++;
        if (!rst_n) begin
            m_st = 0;
            m_prev_sck = 1'b0;
        end
        active = (m_st == 1) && !cs_n;
        exp_v[5] = active && sck && !m_prev_sck;
        exp_v[4] = active && !sck && m_prev_sck;
        exp_v[3] = active && eng_so_en;
        exp_v[2] = active && eng_so_en && eng_so[0];
        exp_v[1] = (m_st == 2);
        exp_v[0] = (m_st == 2) && cs_n;
        act_v = {sck_rise_en, sck_fall_en, so_oe, so_data[0], hold_active, cmd_abort};
        check(act_v === exp_v, cur_req, int'(act_v), int'(exp_v));
        if (sck_rise_en) rise_cnt++;
        if (rst_n) begin
            case (m_st)
                0: if (!cs_n) m_st = 1;
                1: if (cs_n) m_st = 0; else if (!hold_n && !sck) m_st = 2;
                default: if (cs_n) m_st = 0; else if (hold_n && !sck) m_st = 1;
            endcase
            m_prev_sck = sck;
        end
        if (cycles > 20000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; eng_so = ~eng_so; cyc(2);
            sck = 1'b0; cyc(2);
        end
    endtask

    initial begin
        // R1: reset
        cur_req = "R1";
        cyc(3);
        check(hold_active === 1'b0 && so_oe === 1'b0, "R1", hold_active, 0);
        rst_n = 1'b1;
        cyc(1);
        check(sck_rise_en === 1'b0 && cmd_abort === 1'b0, "R1", sck_rise_en, 0);

        // R2: deselected, clock and hold activity ignored
        cur_req = "R2";
        eng_so_en = 1'b1;
        hold_n = 1'b0; pulse(3); hold_n = 1'b1; cyc(2);
        check(hold_active === 1'b0, "R2", hold_active, 0);
        check(rise_cnt == 0, "R2", rise_cnt, 0);

        // R3 / R10: plain burst with output data
        cur_req = "R3";
        cs_n = 1'b0; cyc(2);
        rise_cnt = 0;
        pulse(8);
        check(rise_cnt == 8, "R3", rise_cnt, 8);
        cur_req = "R10";
        eng_so_en = 1'b0; pulse(1); eng_so_en = 1'b1; eng_so = 1'b1; cyc(1);
        check(so_oe === 1'b1 && so_data === 1'b1, "R10", so_oe, 1);

        // R4 / R6 / R7: pause with the clock low, activity while paused
        cur_req = "R4";
        rise_cnt = 0;
        pulse(3);
        hold_n = 1'b0; cyc(1);
        check(hold_active === 1'b1, "R4", hold_active, 1);
        cur_req = "R6";
        pulse(4);
        check(so_oe === 1'b0 && so_data === 1'b0, "R6", so_oe, 0);
        cur_req = "R7";
        hold_n = 1'b1; cyc(1);
        check(hold_active === 1'b0, "R7", hold_active, 0);
        pulse(5);
        check(rise_cnt == 8, "R7", rise_cnt, 8);

        // R5: pause request while clock high is deferred
        cur_req = "R5";
        sck = 1'b1; cyc(1);
        hold_n = 1'b0; cyc(3);
        check(hold_active === 1'b0, "R5", hold_active, 0);
        sck = 1'b0; cyc(1);
        check(hold_active === 1'b1, "R5", hold_active, 1);

        // R8: release while clock high is deferred
        cur_req = "R8";
        sck = 1'b1; cyc(2);
        hold_n = 1'b1; cyc(3);
        check(hold_active === 1'b1, "R8", hold_active, 1);
        sck = 1'b0; cyc(1);
        check(hold_active === 1'b0, "R8", hold_active, 0);

        // R9: chip select rises during a pause
        cur_req = "R9";
        pulse(2);
        hold_n = 1'b0; cyc(2);
        cs_n = 1'b1; #5;
        check(cmd_abort === 1'b1, "R9", cmd_abort, 1);
        cyc(1);
        check(hold_active === 1'b0 && cmd_abort === 1'b0, "R9", hold_active, 0);
        hold_n = 1'b1; cyc(2);
        cs_n = 1'b0; cyc(2);
        rise_cnt = 0;
        pulse(2);
        check(rise_cnt == 2, "R9", rise_cnt, 2);
        cs_n = 1'b1; #5;
        check(cmd_abort === 1'b0, "R9", cmd_abort, 0);
        cyc(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule